// File: doc/BRIEF.md
# I/O Translation Unit Configuration Register Bank

This block holds the software-visible configuration of an I/O address translation unit. A simple 32-bit bus reaches it with a word index (the byte offset shifted right by two), a write strobe and a read strobe. The bank keeps the control word, the page-table base, two flush words, a set of per-slot configuration words and an arbitration-enable word. Each of these keeps only the bits of its own write mask and adds its own constant bits. Read data is combinational from the stored state.

The 3-bit range code in the control word selects how large the translated window is, from 16 MB (code 0) up to 2 GB (code 7), with the size doubling per step. The window always ends at the top of the 32-bit space. The bank turns that code into the window's start address and drives it to the translation engine, together with the enable bit, the table base and the per-slot bypass bits. The fault status and fault address words are visible on the bus, but only the translation engine loads them, through a dedicated capture port.

Top module: `iommu_cfg_regs`

## Requirements
- R1: A synchronous, active-high reset sets every word to zero except three. Control reads `{VERSION, 24'h0}`, arbitration-enable reads 0x00000008 and fault status reads 0x00800000. After reset `win_base` is 0xFF000000 and `xlat_en` is 0.
- R2: A write to word index 0x000 (control) keeps only the bits in 0x0000001D. The value read back is the kept bits OR `VERSION` placed in bits [31:24]. `xlat_en` follows the stored bit 0.
- R3: `win_base` equals 2^32 minus 2^(24+c), where c is the stored control bits [4:2]. Code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: A write to index 0x001 (table base) stores the written value AND 0x07FFFC00. `tbl_base` drives the stored value.
- R5: Writes to index 0x005 (full flush word) and index 0x006 (page flush word) store all 32 bits.
- R6: Slot words sit at indices 0x404 + s for s = 0 to N_SLOT-1. Each keeps only the bits in 0x00010003, and `slot_bypass[s]` is that slot's stored bit 0.
- R7: A write to index 0x800 (arbitration enable) keeps the bits in 0x001F0000, and the word always reads with bit 3 set.
- R8: Fault status (index 0x400) and fault address (index 0x401) are loaded only when `flt_we` is high. Status is stored as `flt_status` OR 0x00800000, and address as `flt_addr`. Bus writes to these two indices have no effect.
- R9: Indices 0x002, 0x003, 0x004 and 0x007 are scratch words that store all 32 written bits. Every other index reads zero and ignores writes.
- R10: `bus_rdata` shows the addressed word in the same cycle `bus_rd` is high, and it is zero while `bus_rd` is low. A read in the same cycle as a write to the same index returns the value held before that write.
- R11: When `flt_we` and a bus write to another word fall in the same cycle, both updates take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_idx | input | IDX_W | Word index (byte offset >> 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| flt_we | input | 1 | Fault capture strobe from the translation engine |
| flt_status | input | 32 | Fault status to capture |
| flt_addr | input | 32 | Faulting address to capture |
| win_base | output | 32 | Start address of the translated window |
| xlat_en | output | 1 | Translation enable |
| tbl_base | output | 32 | Page-table base word |
| slot_bypass | output | N_SLOT | Per-slot bypass bits |

## Verification
Two pairs of operations can land in the same cycle.

The first pair is a bus read and a bus write to the same flush word. The bench raises both strobes together and expects the read to return the earlier contents; one cycle later a plain read must return the new value.

The second pair is a fault capture and a bus write to an unrelated word. The bench raises `flt_we` together with a write to the page flush word, then reads all three words back and expects each to hold its new value, with the reserved status bit forced on.

// File: rtl/iommu_cfg_pkg.sv
package iommu_cfg_pkg;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_CTRL,
        RK_TBASE,
        RK_TLBF,
        RK_PGF,
        RK_FSTAT,
        RK_FADDR,
        RK_SLOT,
        RK_ARB,
        RK_SCR
    } reg_kind_e;

    // word indices (byte offset >> 2)
    localparam logic [31:0] IX_CTRL  = 32'h0000_0000;
    localparam logic [31:0] IX_TBASE = 32'h0000_0001;
    localparam logic [31:0] IX_TLBF  = 32'h0000_0005;
    localparam logic [31:0] IX_PGF   = 32'h0000_0006;
    localparam logic [31:0] IX_FSTAT = 32'h0000_0400;
    localparam logic [31:0] IX_FADDR = 32'h0000_0401;
    localparam logic [31:0] IX_SLOT0 = 32'h0000_0404;
    localparam logic [31:0] IX_ARB   = 32'h0000_0800;

    // keep masks and forced bits
    localparam logic [31:0] CTRL_KEEP  = 32'h0000_001D;
    localparam logic [31:0] TBASE_KEEP = 32'h07FF_FC00;
    localparam logic [31:0] SLOT_KEEP  = 32'h0001_0003;
    localparam logic [31:0] ARB_KEEP   = 32'h001F_0000;
    localparam logic [31:0] ARB_FORCE  = 32'h0000_0008;
    localparam logic [31:0] FSTAT_RSV  = 32'h0080_0000;

    localparam int N_SCR = 4;

endpackage

// File: rtl/iommu_cfg_decode.sv
module iommu_cfg_decode
    import iommu_cfg_pkg::*;
#(
    parameter int IDX_W  = 12,
    parameter int N_SLOT = 4,
    parameter int SUB_W  = 2
) (
    input  logic [IDX_W-1:0] idx,
    output reg_kind_e        kind,
    output logic [SUB_W-1:0] sub
);
    logic [31:0] w;
    assign w = 32'(idx);

    always_comb begin
        kind = RK_NONE;
        sub  = '0;
        if (w == IX_CTRL) begin
            kind = RK_CTRL;
        end else if (w == IX_TBASE) begin
            kind = RK_TBASE;
        end else if (w == IX_TLBF) begin
            kind = RK_TLBF;
        end else if (w == IX_PGF) begin
            kind = RK_PGF;
        end else if (w >= 32'd2 && w <= 32'd4) begin
            kind = RK_SCR;
            sub  = SUB_W'(w - 32'd2);
        end else if (w == 32'd7) begin
            kind = RK_SCR;
            sub  = SUB_W'(3);
        end else if (w == IX_FSTAT) begin
            kind = RK_FSTAT;
        end else if (w == IX_FADDR) begin
            kind = RK_FADDR;
        end else if (w >= IX_SLOT0 && w < IX_SLOT0 + 32'(N_SLOT)) begin
            kind = RK_SLOT;
            sub  = SUB_W'(w - IX_SLOT0);
        end else if (w == IX_ARB) begin
            kind = RK_ARB;
        end
    end
endmodule

// File: rtl/iommu_win_decode.sv
module iommu_win_decode #(
    parameter int ADDR_W   = 32,
    parameter int CODE_W   = 3,
    parameter int MIN_LOG2 = 24
) (
    input  logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] base
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    always_comb begin
        base = ALL_ONES << (MIN_LOG2 + int'(code));
    end
endmodule

// File: rtl/iommu_cfg_regs.sv
module iommu_cfg_regs
    import iommu_cfg_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41,
    parameter int         IDX_W   = 12,
    parameter int         N_SLOT  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              flt_we,
    input  logic [31:0]       flt_status,
    input  logic [31:0]       flt_addr,
    output logic [31:0]       win_base,
    output logic              xlat_en,
    output logic [31:0]       tbl_base,
    output logic [N_SLOT-1:0] slot_bypass
);
    localparam int SUB_W = 2;
    localparam logic [31:0] VER_WORD = {VERSION, 24'h0};

    typedef struct packed {
        logic [31:0]             ctrl;
        logic [31:0]             tbase;
        logic [31:0]             tlbf;
        logic [31:0]             pgf;
        logic [31:0]             fstat;
        logic [31:0]             faddr;
        logic [31:0]             arb;
        logic [N_SLOT-1:0][31:0] slot;
        logic [N_SCR-1:0][31:0]  scr;
    } bank_t;

    bank_t st_d, st_q, st_rst;

    reg_kind_e        kind;
    logic [SUB_W-1:0] sub;

    iommu_cfg_decode #(
        .IDX_W (IDX_W),
        .N_SLOT(N_SLOT),
        .SUB_W (SUB_W)
    ) u_dec (
        .idx (bus_idx),
        .kind(kind),
        .sub (sub)
    );

    iommu_win_decode #(
        .ADDR_W  (32),
        .CODE_W  (3),
        .MIN_LOG2(24)
    ) u_win (
        .code(st_q.ctrl[4:2]),
        .base(win_base)
    );

    always_comb begin
        st_rst       = '0;
        st_rst.ctrl  = VER_WORD;
        st_rst.arb   = ARB_FORCE;
        st_rst.fstat = FSTAT_RSV;
    end

    always_comb begin
        st_d = st_q;
        if (flt_we) begin
            st_d.fstat = flt_status | FSTAT_RSV;
            st_d.faddr = flt_addr;
        end
        if (bus_wr) begin
            case (kind)
                RK_CTRL:  st_d.ctrl  = (bus_wdata & CTRL_KEEP) | VER_WORD;
                RK_TBASE: st_d.tbase = bus_wdata & TBASE_KEEP;
                RK_TLBF:  st_d.tlbf  = bus_wdata;
                RK_PGF:   st_d.pgf   = bus_wdata;
                RK_SLOT:  st_d.slot[sub] = bus_wdata & SLOT_KEEP;
                RK_ARB:   st_d.arb   = (bus_wdata & ARB_KEEP) | ARB_FORCE;
                RK_SCR:   st_d.scr[sub] = bus_wdata;
                default:  ;
            endcase
        end
        if (rst) begin
            st_d = st_rst;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (kind)
                RK_CTRL:  bus_rdata = st_q.ctrl;
                RK_TBASE: bus_rdata = st_q.tbase;
                RK_TLBF:  bus_rdata = st_q.tlbf;
                RK_PGF:   bus_rdata = st_q.pgf;
                RK_FSTAT: bus_rdata = st_q.fstat;
                RK_FADDR: bus_rdata = st_q.faddr;
                RK_SLOT:  bus_rdata = st_q.slot[sub];
                RK_ARB:   bus_rdata = st_q.arb;
                RK_SCR:   bus_rdata = st_q.scr[sub];
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign xlat_en  = st_q.ctrl[0];
    assign tbl_base = st_q.tbase;

    for (genvar s = 0; s < N_SLOT; s++) begin : g_byp
        assign slot_bypass[s] = st_q.slot[s][0];
    end
endmodule

// File: rtl/iommu_cfg_chk.sv
module iommu_cfg_chk
    import iommu_cfg_pkg::*;
#(
    parameter logic [7:0] VERSION = 8'h41,
    parameter int         IDX_W   = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [IDX_W-1:0] bus_idx,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             flt_we,
    input logic [31:0]      flt_status,
    input logic [31:0]      win_base,
    input logic             xlat_en,
    input logic [31:0]      tbl_base
);
    logic [31:0] w;
    assign w = 32'(bus_idx);

    AST_CTRL_VERSION: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && w == IX_CTRL) |-> bus_rdata[31:24] == VERSION); // R2

    AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!rst && bus_wr && w == IX_CTRL) |=> xlat_en == $past(bus_wdata[0])); // R2

    AST_WIN_TOP_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        ($countones((~win_base) + 32'd1) == 1) && win_base[31]); // R3

    AST_TBASE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!rst && bus_wr && w == IX_TBASE) |=> tbl_base == ($past(bus_wdata) & TBASE_KEEP)); // R4

    AST_ARB_FORCED: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && w == IX_ARB) |-> (bus_rdata[3] && ((bus_rdata & ~(ARB_KEEP | ARB_FORCE)) == 32'd0))); // R7

    AST_FAULT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!rst && flt_we) |=> (!(bus_rd && w == IX_FSTAT) || bus_rdata == ($past(flt_status) | FSTAT_RSV))); // R8

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == 32'd0); // R10
endmodule

bind iommu_cfg_regs iommu_cfg_chk #(
    .VERSION(VERSION),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .flt_we    (flt_we),
    .flt_status(flt_status),
    .win_base  (win_base),
    .xlat_en   (xlat_en),
    .tbl_base  (tbl_base)
);

// File: tb/iommu_cfg_regs_test.sv
module iommu_cfg_regs_test;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] VER        = 8'h41;
    localparam int         IDX_W      = 12;
    localparam int         N_SLOT     = 4;
    localparam int         N_VEC      = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [IDX_W-1:0]  bus_idx = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              flt_we = 1'b0;
    logic [31:0]       flt_status = '0;
    logic [31:0]       flt_addr = '0;
    logic [31:0]       win_base;
    logic              xlat_en;
    logic [31:0]       tbl_base;
    logic [N_SLOT-1:0] slot_bypass;

    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iommu_cfg_regs #(.VERSION(VER), .IDX_W(IDX_W), .N_SLOT(N_SLOT)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flt_we(flt_we), .flt_status(flt_status), .flt_addr(flt_addr),
        .win_base(win_base), .xlat_en(xlat_en), .tbl_base(tbl_base),
        .slot_bypass(slot_bypass)
    );

    // {requirement number, word index, write data, expected read-back}
    localparam logic [83:0] VEC [N_VEC] = '{
        {8'd2, 12'h000, 32'hFFFF_FFFF, 32'h4100_001D}, // R2
        {8'd4, 12'h001, 32'hFFFF_FFFF, 32'h07FF_FC00}, // R4
        {8'd5, 12'h005, 32'hA5A5_5A5A, 32'hA5A5_5A5A}, // R5
        {8'd5, 12'h006, 32'h1234_5678, 32'h1234_5678}, // R5
        {8'd6, 12'h404, 32'hFFFF_FFFF, 32'h0001_0003}, // R6
        {8'd6, 12'h407, 32'h0000_0002, 32'h0000_0002}, // R6
        {8'd7, 12'h800, 32'hFFFF_FFFF, 32'h001F_0008}, // R7
        {8'd7, 12'h800, 32'h0000_0000, 32'h0000_0008}, // R7
        {8'd9, 12'h003, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R9
        {8'd9, 12'h100, 32'hFFFF_FFFF, 32'h0000_0000}, // R9
        {8'd8, 12'h400, 32'hFFFF_FFFF, 32'h0080_0000}, // R8
        {8'd2, 12'h000, 32'h0000_0000, 32'h4100_0000}  // R2
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [IDX_W-1:0] idx, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_idx = idx;
        bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [IDX_W-1:0] idx, output logic [31:0] data);
        bus_rd = 1'b1;
        bus_idx = idx;
        #1;
        data = bus_rdata;
        bus_rd = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        do_read(12'h000, rd); check("R1 ctrl", rd, 32'h4100_0000);
        do_read(12'h800, rd); check("R1 arb", rd, 32'h0000_0008);
        do_read(12'h400, rd); check("R1 fstat", rd, 32'h0080_0000);
        do_read(12'h001, rd); check("R1 tbase", rd, 32'h0);
        do_read(12'h405, rd); check("R1 slot1", rd, 32'h0);
        check("R1 win_base", win_base, 32'hFF00_0000);
        check("R1 xlat_en", 32'(xlat_en), 32'h0);

        // table walk: write, then read back
        for (int i = 0; i < N_VEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][83:76], i);
            do_write(VEC[i][75:64], VEC[i][63:32]);
            do_read(VEC[i][75:64], rd);
            check(tag, rd, VEC[i][31:0]);
        end

        // R4 table base port
        check("R4 tbl_base", tbl_base, 32'h07FF_FC00);
        // R6 bypass bits: slot0 bit0=1, slot3 bit0=0
        check("R6 slot_bypass", 32'(slot_bypass), 32'h1);

        // R3 window sweep with enable set (R2 enable bit)
        for (int c = 0; c < 8; c++) begin
            do_write(12'h000, 32'(c << 2) | 32'h1);
            check($sformatf("R3 win code%0d", c), win_base, 32'hFFFF_FFFF << (24 + c));
            check("R2 xlat_en set", 32'(xlat_en), 32'h1);
        end
        do_write(12'h000, 32'h0000_0014);
        check("R2 xlat_en clear", 32'(xlat_en), 32'h0);
        check("R3 win code5", win_base, 32'hE000_0000);

        // R10 idle read data and same-cycle read/write
        bus_idx = 12'h005;
        #1;
        check("R10 idle zero", bus_rdata, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_idx = 12'h005; bus_wdata = 32'h1111_2222;
        #1;
        check("R10 old value", bus_rdata, 32'hA5A5_5A5A);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        do_read(12'h005, rd); check("R10 new value", rd, 32'h1111_2222);

        // R8 / R11 fault capture concurrent with a bus write
        @(negedge clk);
        flt_we = 1'b1; flt_status = 32'h4002_0000; flt_addr = 32'hCAFE_0000;
        bus_wr = 1'b1; bus_idx = 12'h006; bus_wdata = 32'h0BAD_F00D;
        @(negedge clk);
        flt_we = 1'b0; bus_wr = 1'b0;
        do_read(12'h400, rd); check("R8 fstat", rd, 32'h4082_0000);
        do_read(12'h401, rd); check("R8 faddr", rd, 32'hCAFE_0000);
        do_read(12'h006, rd); check("R11 bus write kept", rd, 32'h0BAD_F00D);
        do_write(12'h401, 32'hFFFF_FFFF);
        do_read(12'h401, rd); check("R8 faddr bus ignored", rd, 32'hCAFE_0000);

        // R9 other scratch word
        do_write(12'h007, 32'h0F0F_F0F0);
        do_read(12'h007, rd); check("R9 scratch7", rd, 32'h0F0F_F0F0);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_read(12'h000, rd); check("R1 ctrl again", rd, 32'h4100_0000);
        do_read(12'h005, rd); check("R1 tlbf cleared", rd, 32'h0);
        do_read(12'h003, rd); check("R1 scratch cleared", rd, 32'h0);
        do_read(12'h400, rd); check("R1 fstat again", rd, 32'h0080_0000);
        check("R1 win again", win_base, 32'hFF00_0000);

        finish_run();
    end
endmodule